// File: doc/BRIEF.md
# Butterfly Add-Compare-Select Metric Unit

This block performs the path-metric update for a 16-state trellis decoder of a rate one-half code with constraint length five. For each received symbol it takes two 3-bit soft values and turns them into two signed branch weights. It then runs eight butterfly steps on a single shared add-compare-select datapath, one step per clock. Each step keeps the larger of two candidate metrics for each of two successor states and records which predecessor won.

The sixteen decision bits of one symbol are collected into one 16-bit word, which a later traceback stage consumes. Metrics live in two register banks. One bank is read as the previous interval and the other is written as the current interval, and the two swap roles after every symbol. An upstream unit presents a symbol with a one-cycle strobe while the block is idle. A downstream unit takes the decision word when its valid pulse appears.

Top module: `acs_metric_unit`

## Requirements
- R1: After reset, busy and trn_valid are low, the metric of state 0 is 0, and every other state metric is -32768.
- R2: A soft code with MSB 0 and low bits v has the value v+1 (000 gives +1, 011 gives +4). A soft code with MSB 1 and low bits v has the value v-4 (100 gives -4, 111 gives -1).
- R3: For each symbol, the weight s = a0+a1 is used in butterflies 0 to 3, and the weight t = a0-a1 is used in butterflies 4 to 7. Here a0 is the value of sd0 and a1 the value of sd1.
- R4: Butterfly j reads old states 2j and 2j+1 and writes new states j and j+8. For even j, new(j)=max(old(2j)+w, old(2j+1)-w) and new(j+8)=max(old(2j)-w, old(2j+1)+w). For odd j the signs on w are swapped. The decision bit is 1 only when the odd-state candidate is strictly larger, so a tie gives 0.
- R5: In trn_word, the decision for new state j sits at bit 15-2j and the decision for state j+8 sits at bit 14-2j, for j = 0 to 7. Bit 15 belongs to state 0 and bit 0 to state 15.
- R6: A symbol is taken on a clock edge where sym_valid is high and busy is low. busy then stays high for exactly 8 cycles. trn_valid is high for one cycle, in the first cycle after busy falls, with the complete word on trn_word.
- R7: sym_valid and the soft inputs are ignored while busy is high.
- R8: Every metric addition saturates to the range -32768..32767.
- R9: The metrics written for one symbol are the old metrics used by the next symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | Strobe presenting a new symbol |
| sd0 | input | 3 | Soft value of first coded bit |
| sd1 | input | 3 | Soft value of second coded bit |
| busy | output | 1 | Butterfly sequence in progress |
| trn_valid | output | 1 | One-cycle pulse, decision word ready |
| trn_word | output | 16 | Packed decision bits of one symbol |

## Verification
The hardest condition to reach from the ports is metric saturation at the top of the range. Metrics can only grow by at most eight per symbol, so saturation needs thousands of symbols with the strongest agreeing soft values. Once several candidates clip to the same ceiling, ties appear and the tie rule for decision bits is exercised. The stimulus therefore holds sym_valid high with both inputs at the most confident positive code for more than 4096 symbols. A behavioural model with unbounded integer arithmetic and explicit clamping predicts every word throughout this phase. Short directed symbols taken from reset check the negative-weight and difference-weight paths against hand-computed words.

// File: rtl/acs_pkg.sv
package acs_pkg;

    // sign pattern of one butterfly step
    typedef enum logic {
        BF_DIRECT  = 1'b0,
        BF_REVERSE = 1'b1
    } bfly_kind_e;

endpackage

// File: rtl/acs_soft_map.sv
module acs_soft_map #(
    parameter int SW = 3,
    parameter int LW = SW + 1
) (
    input  logic [SW-1:0]        code,
    output logic signed [LW-1:0] val
);
    localparam logic signed [LW-1:0] ONE  = LW'(1);
    localparam logic signed [LW-1:0] HALF = LW'(2 ** (SW - 1));

    logic signed [LW-1:0] mag;

    always_comb begin
        mag = $signed({2'b00, code[SW-2:0]});
        if (code[SW-1]) begin
            val = mag - HALF;   // negative side: 100 -> -4 ... 111 -> -1
        end else begin
            val = mag + ONE;    // positive side: 000 -> +1 ... 011 -> +4
        end
    end

endmodule

// File: rtl/acs_bfly.sv
module acs_bfly
    import acs_pkg::*;
#(
    parameter int MW = 16,
    parameter int DW = 5
) (
    input  logic signed [MW-1:0] m_up,
    input  logic signed [MW-1:0] m_lo,
    input  logic signed [DW-1:0] w,
    input  bfly_kind_e           kind,
    output logic signed [MW-1:0] nm_j,
    output logic signed [MW-1:0] nm_j8,
    output logic                 dec_j,
    output logic                 dec_j8
);
    localparam logic signed [MW:0] HI = (MW+1)'((1 << (MW - 1)) - 1);
    localparam logic signed [MW:0] LO = -HI - (MW+1)'(1);

    function automatic logic signed [MW-1:0] sat_add(input logic signed [MW-1:0] a,
                                                      input logic signed [DW-1:0] b);
        logic signed [MW:0] s;
        s = (MW+1)'(a) + (MW+1)'(b);
        if (s > HI) begin
            return HI[MW-1:0];
        end else if (s < LO) begin
            return LO[MW-1:0];
        end
        return s[MW-1:0];
    endfunction

    logic signed [DW-1:0] wp, wn;
    logic signed [MW-1:0] c_j_up, c_j_lo, c_j8_up, c_j8_lo;

    always_comb begin
        wp      = (kind == BF_DIRECT) ? w : -w;
        wn      = -wp;
        c_j_up  = sat_add(m_up, wp);
        c_j_lo  = sat_add(m_lo, wn);
        c_j8_up = sat_add(m_up, wn);
        c_j8_lo = sat_add(m_lo, wp);
        dec_j   = c_j_lo > c_j_up;
        dec_j8  = c_j8_lo > c_j8_up;
        nm_j    = dec_j  ? c_j_lo  : c_j_up;
        nm_j8   = dec_j8 ? c_j8_lo : c_j8_up;
    end

endmodule

// File: rtl/acs_metric_unit.sv
module acs_metric_unit
    import acs_pkg::*;
#(
    parameter int K  = 5,
    parameter int SW = 3,
    parameter int MW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_valid,
    input  logic [SW-1:0]            sd0,
    input  logic [SW-1:0]            sd1,
    output logic                     busy,
    output logic                     trn_valid,
    output logic [(1 << (K-1))-1:0]  trn_word
);
    localparam int NS = 1 << (K - 1);
    localparam int NB = NS / 2;
    localparam int CW = $clog2(NB);
    localparam int LW = SW + 1;
    localparam int DW = SW + 2;
    localparam logic [MW-1:0] M_FLOOR = {1'b1, {(MW-1){1'b0}}};

    typedef struct packed {
        logic                              busy;
        logic [CW-1:0]                     cnt;
        logic                              bank_sel;
        logic signed [DW-1:0]              sum;
        logic signed [DW-1:0]              diff;
        logic [NS-1:0]                     trn_sh;
        logic                              trn_valid;
        logic [1:0][NS-1:0][MW-1:0]        bank;
    } st_t;

    st_t st_d, st_q;

    logic signed [LW-1:0] a0, a1;
    logic signed [MW-1:0] old_up, old_lo, nm_j, nm_j8;
    logic signed [DW-1:0] w_sel;
    logic                 dec_j, dec_j8;
    bfly_kind_e           kind;

    acs_soft_map #(.SW(SW), .LW(LW)) u_map0 (.code(sd0), .val(a0));
    acs_soft_map #(.SW(SW), .LW(LW)) u_map1 (.code(sd1), .val(a1));

    always_comb begin
        old_up = $signed(st_q.bank[st_q.bank_sel][{st_q.cnt, 1'b0}]);
        old_lo = $signed(st_q.bank[st_q.bank_sel][{st_q.cnt, 1'b1}]);
        w_sel  = st_q.cnt[CW-1] ? st_q.diff : st_q.sum;
        kind   = st_q.cnt[0] ? BF_REVERSE : BF_DIRECT;
    end

    acs_bfly #(.MW(MW), .DW(DW)) u_bfly (
        .m_up   (old_up),
        .m_lo   (old_lo),
        .w      (w_sel),
        .kind   (kind),
        .nm_j   (nm_j),
        .nm_j8  (nm_j8),
        .dec_j  (dec_j),
        .dec_j8 (dec_j8)
    );

    always_comb begin
        st_d           = st_q;
        st_d.trn_valid = 1'b0;
        if (!st_q.busy) begin
            if (sym_valid) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.sum  = DW'(a0) + DW'(a1);
                st_d.diff = DW'(a0) - DW'(a1);
            end
        end else begin
            st_d.bank[~st_q.bank_sel][{1'b0, st_q.cnt}] = nm_j;
            st_d.bank[~st_q.bank_sel][{1'b1, st_q.cnt}] = nm_j8;
            st_d.trn_sh = {st_q.trn_sh[NS-3:0], dec_j, dec_j8};
            if (st_q.cnt == CW'(NB - 1)) begin
                st_d.busy      = 1'b0;
                st_d.bank_sel  = ~st_q.bank_sel;
                st_d.trn_valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int b = 0; b < 2; b++) begin
                for (int s = 1; s < NS; s++) begin
                    st_q.bank[b][s] <= M_FLOOR;
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign trn_valid = st_q.trn_valid;
    assign trn_word  = st_q.trn_sh;

    // R6: an idle strobe starts the sequence on the next cycle
    a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !busy) |=> busy);

    // R6: the word is flagged only right after the busy phase
    a_r6_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        trn_valid |-> (!busy && $past(busy)));

    // R6: the valid flag lasts a single cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trn_valid |=> !trn_valid);

    // R6: every sequence starts at butterfly 0
    a_r6_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (st_q.cnt == '0));

    // R7: strobes during the busy phase leave the weights untouched
    a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sym_valid && st_q.cnt != CW'(NB - 1)) |=> (busy && $stable(st_q.sum) && $stable(st_q.diff)));

    // R9: metrics change only during the busy phase
    a_r9_idle_banks_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(st_q.bank));

endmodule

// File: tb/acs_metric_unit_tb.sv
`timescale 1ns/1ps
module acs_metric_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [2:0]  sd0 = 3'd0;
    logic [2:0]  sd1 = 3'd0;
    logic        busy;
    logic        trn_valid;
    logic [15:0] trn_word;

    int checks = 0;
    int fails  = 0;
    string tag = "R5";

    always #4 clk = ~clk;

    acs_metric_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sd0       (sd0),
        .sd1       (sd1),
        .busy      (busy),
        .trn_valid (trn_valid),
        .trn_word  (trn_word)
    );

    // ---------------- behavioural reference ----------------
    int          m_met [16];
    int          m_busy;
    bit          m_tv;
    logic [15:0] m_word;

    function automatic int soft_val(input logic [2:0] c);   // R2 table
        case (c)
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 3;
            3'b011: return 4;
            3'b100: return -4;
            3'b101: return -3;
            3'b110: return -2;
            default: return -1;
        endcase
    endfunction

    function automatic int clamp(input int v);               // R8
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic model_symbol(input logic [2:0] c0, input logic [2:0] c1);
        int nxt [16];
        int s_w = soft_val(c0) + soft_val(c1);
        int t_w = soft_val(c0) - soft_val(c1);
        for (int s = 0; s < 16; s++) begin
            int j  = s % 8;
            int wv = (j < 4) ? s_w : t_w;
            int up_sign = ((j % 2 == 0) == (s < 8)) ? 1 : -1;
            int cu = clamp(m_met[(2 * j) % 16] + up_sign * wv);
            int cl = clamp(m_met[(2 * j) % 16 + 1] - up_sign * wv);
            bit pick = (cl > cu);
            nxt[s] = pick ? cl : cu;
            m_word[15 - (2 * j + ((s >= 8) ? 1 : 0))] = pick;
        end
        for (int s = 0; s < 16; s++) m_met[s] = nxt[s];
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < 16; s++) m_met[s] = (s == 0) ? 0 : -32768;
            m_busy = 0;
            m_tv   = 0;
        end else begin
            m_tv = 0;
            if (m_busy > 0) begin
                m_busy = m_busy - 1;
                if (m_busy == 0) m_tv = 1;
            end else if (sym_valid) begin
                model_symbol(sd0, sd1);
                m_busy = 8;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (busy !== (m_busy != 0)) begin
                fails++;
                $display("FAIL R6/R7 busy actual %0b expected %0b", busy, (m_busy != 0));
            end
            checks++;
            if (trn_valid !== m_tv) begin
                fails++;
                $display("FAIL R6 trn_valid actual %0b expected %0b", trn_valid, m_tv);
            end
            if (m_tv) begin
                checks++;
                if (trn_word !== m_word) begin
                    fails++;
                    $display("FAIL %s trn_word actual %h expected %h", tag, trn_word, m_word);
                end
            end
        end
    end

    task automatic check_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sym_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [2:0] c0, input logic [2:0] c1);
        @(negedge clk);
        sym_valid = 1'b1;
        sd0 = c0;
        sd1 = c1;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        do_reset();
        @(negedge clk);
        // R1: idle outputs after reset
        check_val("R1 busy", {15'd0, busy}, 16'd0);
        check_val("R1 trn_valid", {15'd0, trn_valid}, 16'd0);

        // R1 R2 R3 R4 R5: +4,+4 from reset -> hand-computed word
        tag = "R4 R5";
        send(3'b011, 3'b011);
        repeat (8) @(negedge clk);
        check_val("R6 valid at ninth cycle", {15'd0, trn_valid}, 16'd1);
        check_val("R1/R4/R5 word for +4,+4", trn_word, 16'h2600);

        // R2 R3: -4,+4 from reset -> difference weight drives the word
        do_reset();
        tag = "R2 R3";
        send(3'b100, 3'b011);
        repeat (8) @(negedge clk);
        check_val("R2/R3 word for -4,+4", trn_word, 16'h0099);

        // R9: random symbols with gaps, metrics carried across symbols
        tag = "R9";
        for (int i = 0; i < 300; i++) begin
            send(3'($urandom), 3'($urandom));
            repeat ($urandom_range(7, 12)) @(negedge clk);
        end

        // R7: strobe held high with changing inputs during busy
        tag = "R7";
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            sym_valid = 1'b1;
            sd0 = 3'($urandom);
            sd1 = 3'($urandom);
        end
        @(negedge clk);
        sym_valid = 1'b0;
        repeat (12) @(negedge clk);

        // R8: drive metrics into the upper clamp and hold them there
        do_reset();
        tag = "R8";
        @(negedge clk);
        sym_valid = 1'b1;
        sd0 = 3'b011;
        sd1 = 3'b011;
        repeat (4300 * 9) @(negedge clk);
        sym_valid = 1'b0;
        repeat (12) @(negedge clk);
        check_val("R8 idle after saturation run", {15'd0, busy}, 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule